// File: doc/BRIEF.md
# Bit-Masked Control and Status Register Bank for a Storage PHY

This block holds the control word set for a storage-interface PHY. It sits on a simple memory-mapped bus: a byte address, 32-bit write data, a write strobe, a read strobe and 32-bit read data. Seven 16-bit control words live at consecutive word addresses, and a read-only status word sits past them. The control bits drive the PHY's configuration pins directly: power-up, DLL enable, drive strength, DLL frequency band and output tap delay. Two status inputs from the PHY, calibration done and DLL locked, are brought into the clock domain and can be read back.

Every write carries its own bit-enable mask. The upper half of the write data says which bits of the lower half are to be taken, so software can flip a single field, such as the power-up bit, without first reading the word back. Bits whose enable is 0 keep their stored value. Reads return the stored lower half-word, with zeros in the upper half.

Top module: `phyreg_bank`

## Requirements
- R1: On a write to a control word, stored bit x (0 to 15) takes wdata[x] when wdata[x+16] is 1 and keeps its old value when wdata[x+16] is 0.
- R2: The control words sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18; each is stored on its own, and a read returns it in rdata[15:0] with rdata[31:16] equal to 0.
- R3: The word at 0x20 is status: rdata[6] is calibration done, rdata[5] is DLL locked, all other bits read 0, and writes to it change nothing.
- R4: Writes to any other address (0x1C, 0x24 to 0x3C, or any address with addr[1:0] not 0) change no stored bit, and reads of them return 0.
- R5: Synchronous reset clears every control bit and rdata, so the PHY is powered down with the DLL off.
- R6: Word 0x18 drives pwr_up from bit 0, dll_en from bit 1 and drv_sel from bits 6:4 (codes 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm).
- R7: Word 0x00 drives dll_freq from bits 13:12, otap_en from bit 11 and otap_val from bits 10:7.
- R8: rdata is loaded on the clock edge where rd_en is 1 and holds its value on every edge where rd_en is 0.
- R9: Each status input passes two flops before the read mux, so a read captured on the first or second edge after an input change returns the old value and a read on the third edge returns the new one.
- R10: A write and a read to the same control word on the same edge return the value from before the write.
- R11: ctrl_raw carries every control word, word n in bits 16n+15:16n, updated on the edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 6 | Byte address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data; upper half is the bit enable |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| cal_done_i | input | 1 | Calibration done from the PHY |
| dll_lock_i | input | 1 | DLL locked from the PHY |
| pwr_up | output | 1 | PHY power-up (0 = powered down) |
| dll_en | output | 1 | DLL enable |
| drv_sel | output | 3 | Drive impedance code |
| dll_freq | output | 2 | DLL frequency band |
| otap_en | output | 1 | Output tap delay enable |
| otap_val | output | 4 | Output tap delay value |
| ctrl_raw | output | 112 | All control words, flattened |

## Verification
The hardest case to reach is a stored bit meeting a write whose mask bit is 0 while its data bit would flip it. This only shows if the word already holds a mix of ones and zeros and the write data disagrees with it. Random data with an independently random mask, after earlier writes have filled the words, covers every combination of stored bit, mask bit and data bit. The two-edge status delay is hit by issuing back-to-back reads of the status word right on the edge where an input changes.

// File: rtl/phyreg_bank.sv
module phyreg_bank #(
  parameter int ADDR_W   = 6,
  parameter int NCTRL    = 7,
  parameter int STAT_IDX = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic [31:0]           wdata,
  input  logic                  rd_en,
  output logic [31:0]           rdata,
  input  logic                  cal_done_i,
  input  logic                  dll_lock_i,
  output logic                  pwr_up,
  output logic                  dll_en,
  output logic [2:0]            drv_sel,
  output logic [1:0]            dll_freq,
  output logic                  otap_en,
  output logic [3:0]            otap_val,
  output logic [NCTRL*16-1:0]   ctrl_raw
);
  localparam int HW     = 16;
  localparam int WIDX_W = ADDR_W - 2;
  localparam int PWR_W  = NCTRL - 1;
  localparam int CAL_B  = 6;
  localparam int LCK_B  = 5;

  logic [HW-1:0]     creg [NCTRL];
  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [HW-1:0]     wmask, wval;
  logic [1:0]        sync1, sync2;
  logic [31:0]       rd_word;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wmask   = wdata[31:HW];
  assign wval    = wdata[HW-1:0];

  for (genvar i = 0; i < NCTRL; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        creg[i] <= '0;
      else if (wr_en && aligned && widx == WIDX_W'(i))
        creg[i] <= (creg[i] & ~wmask) | (wval & wmask);
    end
    assign ctrl_raw[i*HW +: HW] = creg[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {cal_done_i, dll_lock_i};
      sync2 <= sync1;
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned) begin
      for (int i = 0; i < NCTRL; i++)
        if (widx == WIDX_W'(i)) rd_word[HW-1:0] = creg[i];
      if (widx == WIDX_W'(STAT_IDX)) begin
        rd_word[CAL_B] = sync2[1];
        rd_word[LCK_B] = sync2[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_word;
  end

  assign pwr_up   = creg[PWR_W][0];
  assign dll_en   = creg[PWR_W][1];
  assign drv_sel  = creg[PWR_W][6:4];
  assign dll_freq = creg[0][13:12];
  assign otap_en  = creg[0][11];
  assign otap_val = creg[0][10:7];
endmodule

// File: rtl/phyreg_bank_chk.sv
module phyreg_bank_chk #(
  parameter int ADDR_W   = 6,
  parameter int NCTRL    = 7,
  parameter int STAT_IDX = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic [31:0]         wdata,
  input logic                rd_en,
  input logic [31:0]         rdata,
  input logic                pwr_up,
  input logic [NCTRL*16-1:0] ctrl_raw
);
  localparam logic [ADDR_W-1:0] PWR_ADDR = ADDR_W'((NCTRL - 1) * 4);
  localparam logic [ADDR_W-1:0] STA_ADDR = ADDR_W'(STAT_IDX * 4);

  logic rst_d;
  logic unmapped;
  always_ff @(posedge clk) rst_d <= rst;

  assign unmapped = (addr[1:0] != 2'b00) ||
                    ((int'(addr[ADDR_W-1:2]) >= NCTRL) && (int'(addr[ADDR_W-1:2]) != STAT_IDX));

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == PWR_ADDR && !wdata[16]) |=> $stable(pwr_up)); // R1
  AST_MASK_TAKE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == PWR_ADDR && wdata[16]) |=> (pwr_up == $past(wdata[0]))); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rdata[31:16] == 16'h0)); // R2
  AST_STATUS_BITS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == STA_ADDR) |=> (rdata[31:7] == 25'h0 && rdata[4:0] == 5'h0)); // R3
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && unmapped) |=> (rdata == 32'h0)); // R4
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && unmapped) |=> $stable(ctrl_raw)); // R4
  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == STA_ADDR) |=> $stable(ctrl_raw)); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (ctrl_raw == '0 && rdata == 32'h0)); // R5
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R8
endmodule

bind phyreg_bank phyreg_bank_chk #(.ADDR_W(ADDR_W), .NCTRL(NCTRL), .STAT_IDX(STAT_IDX)) u_chk (.*);

// File: tb/test_phyreg_bank.sv
module test_phyreg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCTRL = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic         rd_en = 1'b0;
  logic [31:0]  rdata;
  logic         cal_done_i = 1'b0;
  logic         dll_lock_i = 1'b0;
  logic         pwr_up, dll_en, otap_en;
  logic [2:0]   drv_sel;
  logic [1:0]   dll_freq;
  logic [3:0]   otap_val;
  logic [NCTRL*16-1:0] ctrl_raw;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [15:0] mdl [NCTRL];
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  phyreg_bank i_phyreg_bank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .cal_done_i(cal_done_i), .dll_lock_i(dll_lock_i),
    .pwr_up(pwr_up), .dll_en(dll_en), .drv_sel(drv_sel), .dll_freq(dll_freq),
    .otap_en(otap_en), .otap_val(otap_val), .ctrl_raw(ctrl_raw)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] a);
    logic [31:0] r = '0;
    if (a[1:0] == 2'b00) begin
      if (int'(a[5:2]) < NCTRL) r[15:0] = mdl[a[5:2]];
      else if (a[5:2] == 4'd8) begin
        r[6] = cal_done_i;
        r[5] = dll_lock_i;
      end
    end
    return r;
  endfunction

  function automatic logic [12:0] exp_pins();
    return {mdl[6][0], mdl[6][1], mdl[6][6:4], mdl[0][13:12], mdl[0][11], mdl[0][10:7]};
  endfunction

  function automatic logic [NCTRL*16-1:0] exp_raw();
    logic [NCTRL*16-1:0] r;
    for (int i = 0; i < NCTRL; i++) r[i*16 +: 16] = mdl[i];
    return r;
  endfunction

  task automatic wr(logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[1:0] == 2'b00 && int'(a[5:2]) < NCTRL) mdl[a[5:2]] = merge(mdl[a[5:2]], d);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic check_pins(string req);
    check(req, 128'({pwr_up, dll_en, drv_sel, dll_freq, otap_en, otap_val}), 128'(exp_pins()));
    check("R11", 128'(ctrl_raw), 128'(exp_raw()));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NCTRL; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R5 pins", 128'({pwr_up, dll_en, drv_sel, dll_freq, otap_en, otap_val, ctrl_raw}), 128'h0);
    check("R5 rdata", 128'(rdata), 128'h0);
    for (int i = 0; i < NCTRL; i++) begin
      rd(6'(i*4), got);
      check("R5 readback", 128'(got), 128'h0);
    end

    // R6: power up alone, then each drive code
    wr(6'h18, 32'h0001_0001);
    check_pins("R6 pwr_up");
    check("R6 pwr_up bit", 128'(pwr_up), 128'(1'b1));
    wr(6'h18, 32'h0002_0002);
    check("R6 dll_en", 128'({pwr_up, dll_en}), 128'(2'b11));
    for (int c = 0; c <= 4; c++) begin
      wr(6'h18, 32'h0070_0000 | 32'(c << 4));
      check("R6 drv_sel", 128'(drv_sel), 128'(c));
      check("R1 other fields kept", 128'({pwr_up, dll_en}), 128'(2'b11));
    end

    // R7: frequency band, tap enable, tap value 4
    wr(6'h00, 32'h3F80_0000 | (32'd3 << 12) | (32'd1 << 11) | (32'd4 << 7));
    check("R7 fields", 128'({dll_freq, otap_en, otap_val}), 128'({2'd3, 1'b1, 4'd4}));
    check_pins("R7 pins");

    // R1: zero mask leaves word unchanged
    wr(6'h04, 32'h0000_FFFF);
    rd(6'h04, got);
    check("R1 zero mask", 128'(got), 128'h0);
    wr(6'h04, 32'hFFFF_A5A5);
    wr(6'h04, 32'h0F0F_FFFF);
    rd(6'h04, got);
    check("R1 partial mask", 128'(got), 128'(32'h0000_AFAF));

    // R3: status read and write-ignore
    cal_done_i = 1'b1; dll_lock_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(6'h20, got);
    check("R3 cal bit", 128'(got), 128'(32'h40));
    wr(6'h20, 32'hFFFF_FFFF);
    check("R3 write ignored", 128'(ctrl_raw), 128'(exp_raw()));
    rd(6'h20, got);
    check("R3 after write", 128'(got), 128'(32'h40));

    // R9: two-edge delay on status
    dll_lock_i = 1'b1;
    rd(6'h20, got);
    check("R9 first edge old", 128'(got), 128'(32'h40));
    rd(6'h20, got);
    check("R9 second edge old", 128'(got), 128'(32'h40));
    rd(6'h20, got);
    check("R9 third edge new", 128'(got), 128'(32'h60));

    // R4: unmapped writes and reads
    old = 32'(mdl[1]);
    wr(6'h1C, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h05, 32'hFFFF_FFFF);
    wr(6'h1A, 32'hFFFF_0000);
    check("R4 writes ignored", 128'(ctrl_raw), 128'(exp_raw()));
    rd(6'h04, got);
    check("R4 word1 intact", 128'(got), 128'(old));
    rd(6'h1C, got);
    check("R4 read 0x1C", 128'(got), 128'h0);
    rd(6'h21, got);
    check("R4 read unaligned", 128'(got), 128'h0);

    // R8: hold while rd_en low
    rd(6'h00, got);
    addr = 6'h18;
    repeat (2) @(negedge clk);
    check("R8 hold", 128'(rdata), 128'(exp_read(6'h00)));

    // R10: simultaneous write and read
    old = exp_read(6'h08);
    addr = 6'h08; wdata = 32'hFFFF_1234; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    mdl[2] = merge(mdl[2], 32'hFFFF_1234);
    check("R10 old value", 128'(rdata), 128'(old));
    rd(6'h08, got);
    check("R10 new value", 128'(got), 128'(32'h1234));

    // Random traffic, R1 R2 R4
    for (int n = 0; n < 400; n++) begin
      logic [5:0] a;
      logic [31:0] d;
      a = {4'($urandom % 16), (($urandom % 8) == 0) ? 2'($urandom) : 2'b00};
      d = $urandom;
      wr(a, d);
      check_pins("R1 random pins");
      a = {4'($urandom % 16), (($urandom % 8) == 0) ? 2'($urandom) : 2'b00};
      rd(a, got);
      check("R2 random read", 128'(got), 128'(exp_read(a)));
    end

    // R2: all words distinct
    for (int i = 0; i < NCTRL; i++) wr(6'(i*4), 32'hFFFF_0000 | 32'(16'h1111 * (i + 1)));
    for (int i = 0; i < NCTRL; i++) begin
      rd(6'(i*4), got);
      check("R2 word", 128'(got), 128'(32'(16'h1111 * (i + 1))));
    end

    // R5: reset again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NCTRL; i++) mdl[i] = '0;
    check("R5 second reset", 128'({ctrl_raw, rdata}), 128'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule